// File: doc/BRIEF.md
# Two-Way Set Combiner with Toggle Replacement

This block is the glue that turns two direct-mapped storage ways into one two-way set-associative cache. Both ways are looked up in parallel with the same index and offset. The block receives each way's tag-match, valid, dirty, tag and data signals, together with the request controls: enable, compare and write. It returns a single qualified hit, the read fields taken from the way that matters, the chosen victim way, and per-way enable and write strobes for the two storage ways.

Replacement uses a single toggle bit. The bit flips on every access that the pipeline counts. A separate count input lets the surrounding control leave out idle, invalid or squashed operations. On a miss, an invalid way is always preferred over a valid one. The toggle bit is consulted only when both ways hold valid lines.

The chosen victim is captured at the miss and held. The following refill and writeback steps, which use the non-compare access modes, therefore always reach the same way, whatever the toggle bit does in the meantime. The whole datapath is combinational apart from two flops. There is no stream interface and no back-pressure: all pins are plain control and status lines, sampled on the rising clock edge.

Top module: `way_pair_ctrl`

## Requirements
- R1: `hit` is 1 only when `req_en` and `req_cmp` are both 1 and at least one way has both `way_hit[w]` and `way_valid[w]` set. A tag match on an invalid line gives `hit` = 0.
- R2: On a compare lookup that hits, `rd_data`, `rd_tag`, `rd_valid` and `rd_dirty` come from the hitting way. If both ways qualify, way 0 wins.
- R3: On a compare miss where exactly one way is valid, the victim is the other way. Where neither way is valid, the victim is way 0.
- R4: On a compare miss where both ways are valid, the victim equals the replacement bit after the toggle made by that same access.
- R5: The replacement bit is 0 after reset. It inverts at each rising edge where `req_en` and `req_count` are both 1, and it holds at every other edge.
- R6: `victim_way` is a register. It loads the victim on a rising edge that ends a compare miss with `req_en` and `req_count` both 1. At all other edges it holds its value. It is 0 after reset.
- R7: On a compare miss, the read fields come from the victim chosen in that cycle. With `req_cmp` = 0, the read fields come from the way in `victim_way`.
- R8: With `req_en` = 1, `req_cmp` = 0 and `req_wr` = 1, only bit `victim_way` of `way_wr` is 1. `way_en` is likewise one-hot on that way.
- R9: With `req_en` = 1, `req_cmp` = 1 and `req_wr` = 1, both bits of `way_wr` are 1. With `req_cmp` = 1, both bits of `way_en` are 1.
- R10: With `req_en` = 0, the following outputs are all 0: `hit`, `rd_data`, `rd_tag`, `rd_valid`, `rd_dirty`, `way_en` and `way_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| req_en | input | 1 | Request enable |
| req_cmp | input | 1 | 1 = tag-compare access, 0 = raw access to the held victim way |
| req_wr | input | 1 | Write request |
| req_count | input | 1 | Access counts toward replacement and may capture a victim |
| way_hit | input | 2 | Per-way tag match |
| way_valid | input | 2 | Per-way valid bit of the indexed line |
| way_dirty | input | 2 | Per-way dirty bit of the indexed line |
| way_tag | input | 2 x TAG_W | Per-way stored tag |
| way_data | input | 2 x DATA_W | Per-way read word |
| hit | output | 1 | Qualified combined hit |
| rd_data | output | DATA_W | Selected read word |
| rd_tag | output | TAG_W | Selected tag |
| rd_valid | output | 1 | Selected valid bit |
| rd_dirty | output | 1 | Selected dirty bit |
| victim_way | output | 1 | Held victim way |
| way_en | output | 2 | Per-way enable strobes |
| way_wr | output | 2 | Per-way write strobes |

## Verification
Several properties are checked on every cycle. These are the hit qualification, the gating while disabled, the strobe shapes in compare and raw modes, the holding of `victim_way` between captures, and the victim rules for zero, one or two valid ways. The both-valid rule is checked against a shadow parity of counted accesses. Some behaviour can only be shown by the bench's scenarios. These cover the read-field source under all mode and hit combinations, and the way the toggle bit skips uncounted accesses over long runs. They also include a seven-load install sequence over two sets, driven by behavioural storage, which exercises free-way preference, a hit, and toggle-driven eviction in order.

// File: rtl/way_pair_pkg.sv
package way_pair_pkg;
  typedef enum logic {
    WAY_A = 1'b0,
    WAY_B = 1'b1
  } way_id_t;

  localparam int unsigned NUM_WAYS = 2;

  function automatic logic [NUM_WAYS-1:0] way_onehot(input way_id_t w);
    logic [NUM_WAYS-1:0] r;
    r = '0;
    r[w] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/wp_hit_resolve.sv
module wp_hit_resolve
  import way_pair_pkg::*;
(
  input  logic                lookup,
  input  logic [NUM_WAYS-1:0] tag_match,
  input  logic [NUM_WAYS-1:0] line_valid,
  output logic                any_hit,
  output way_id_t             hit_way
);
  logic [NUM_WAYS-1:0] qual;

  always_comb begin
    qual    = tag_match & line_valid;
    any_hit = lookup & (|qual);
    hit_way = qual[0] ? WAY_A : WAY_B;
  end
endmodule

// File: rtl/wp_victim_track.sv
module wp_victim_track
  import way_pair_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                counted,
  input  logic                capture,
  input  logic [NUM_WAYS-1:0] line_valid,
  output way_id_t             pick_now,
  output way_id_t             held_victim
);
  logic    toggle_q;
  logic    toggle_post;
  way_id_t held_q;

  always_comb begin
    toggle_post = toggle_q ^ counted;
    unique case (line_valid)
      2'b11:   pick_now = way_id_t'(toggle_post);
      2'b01:   pick_now = WAY_B;
      default: pick_now = WAY_A;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      toggle_q <= 1'b0;
      held_q   <= WAY_A;
    end else begin
      toggle_q <= toggle_post;
      if (capture) held_q <= pick_now;
    end
  end

  assign held_victim = held_q;
endmodule

// File: rtl/wp_read_mux.sv
module wp_read_mux
  import way_pair_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic                        en,
  input  way_id_t                     sel,
  input  logic [NUM_WAYS-1:0][W-1:0] bundle_in,
  output logic [W-1:0]                bundle_out
);
  always_comb begin
    bundle_out = en ? bundle_in[sel] : '0;
  end
endmodule

// File: rtl/wp_strobe_steer.sv
module wp_strobe_steer
  import way_pair_pkg::*;
(
  input  logic                en,
  input  logic                cmp,
  input  logic                wr,
  input  way_id_t             raw_way,
  output logic [NUM_WAYS-1:0] en_out,
  output logic [NUM_WAYS-1:0] wr_out
);
  logic [NUM_WAYS-1:0] raw_mask;

  assign raw_mask = way_onehot(raw_way);

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
    always_comb begin
      en_out[g] = en & (cmp | raw_mask[g]);
      wr_out[g] = en & wr & (cmp | raw_mask[g]);
    end
  end
endmodule

// File: rtl/way_pair_ctrl.sv
module way_pair_ctrl
  import way_pair_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TAG_W  = 5
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              req_en,
  input  logic                              req_cmp,
  input  logic                              req_wr,
  input  logic                              req_count,
  input  logic [1:0]                        way_hit,
  input  logic [1:0]                        way_valid,
  input  logic [1:0]                        way_dirty,
  input  logic [1:0][TAG_W-1:0]             way_tag,
  input  logic [1:0][DATA_W-1:0]            way_data,
  output logic                              hit,
  output logic [DATA_W-1:0]                 rd_data,
  output logic [TAG_W-1:0]                  rd_tag,
  output logic                              rd_valid,
  output logic                              rd_dirty,
  output logic                              victim_way,
  output logic [1:0]                        way_en,
  output logic [1:0]                        way_wr
);
  localparam int unsigned BUNDLE_W = TAG_W + DATA_W + 2;

  logic    lookup;
  logic    counted;
  logic    capture;
  logic    any_hit;
  way_id_t hit_way;
  way_id_t pick_now;
  way_id_t held_victim;
  way_id_t rd_sel;

  logic [NUM_WAYS-1:0][BUNDLE_W-1:0] bundle;
  logic [BUNDLE_W-1:0]               picked;

  assign lookup  = req_en & req_cmp;
  assign counted = req_en & req_count;

  wp_hit_resolve u_hit (
    .lookup     (lookup),
    .tag_match  (way_hit),
    .line_valid (way_valid),
    .any_hit    (any_hit),
    .hit_way    (hit_way)
  );

  assign capture = lookup & req_count & ~any_hit;

  wp_victim_track u_vict (
    .clk         (clk),
    .rst         (rst),
    .counted     (counted),
    .capture     (capture),
    .line_valid  (way_valid),
    .pick_now    (pick_now),
    .held_victim (held_victim)
  );

  always_comb begin
    if (req_cmp) rd_sel = any_hit ? hit_way : pick_now;
    else         rd_sel = held_victim;
  end

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_bundle
    assign bundle[g] = {way_tag[g], way_data[g], way_valid[g], way_dirty[g]};
  end

  wp_read_mux #(.W(BUNDLE_W)) u_mux (
    .en         (req_en),
    .sel        (rd_sel),
    .bundle_in  (bundle),
    .bundle_out (picked)
  );

  assign {rd_tag, rd_data, rd_valid, rd_dirty} = picked;
  assign hit        = any_hit;
  assign victim_way = held_victim;

  wp_strobe_steer u_steer (
    .en      (req_en),
    .cmp     (req_cmp),
    .wr      (req_wr),
    .raw_way (held_victim),
    .en_out  (way_en),
    .wr_out  (way_wr)
  );
endmodule

// File: rtl/way_pair_ctrl_chk.sv
module way_pair_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_en,
  input logic       req_cmp,
  input logic       req_wr,
  input logic       req_count,
  input logic [1:0] way_hit,
  input logic [1:0] way_valid,
  input logic       hit,
  input logic       rd_valid,
  input logic       rd_dirty,
  input logic       victim_way,
  input logic [1:0] way_en,
  input logic [1:0] way_wr
);
  logic shadow_par;
  logic miss_cnt;

  always_ff @(posedge clk) begin
    if (rst) shadow_par <= 1'b0;
    else     shadow_par <= shadow_par ^ (req_en & req_count);
  end

  assign miss_cnt = req_en && req_cmp && req_count && !hit;

  p_hit_needs_valid_r1: assert property (@(posedge clk) disable iff (rst)
    hit |-> (req_en && req_cmp && ((way_hit & way_valid) != 2'b00)));
  p_invalid_match_miss_r1: assert property (@(posedge clk) disable iff (rst)
    (req_en && req_cmp && ((way_hit & way_valid) == 2'b00)) |-> !hit);
  p_one_valid_other_r3: assert property (@(posedge clk) disable iff (rst)
    (miss_cnt && way_valid == 2'b01) |=> victim_way);
  p_none_valid_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (miss_cnt && way_valid == 2'b00) |=> !victim_way);
  p_both_valid_toggle_r4: assert property (@(posedge clk) disable iff (rst)
    (miss_cnt && way_valid == 2'b11) |=> (victim_way == shadow_par));
  p_victim_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !miss_cnt |=> $stable(victim_way));
  p_raw_write_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    (req_en && !req_cmp && req_wr) |-> ($countones(way_wr) == 1 && way_wr[victim_way]));
  p_cmp_write_both_r9: assert property (@(posedge clk) disable iff (rst)
    (req_en && req_cmp && req_wr) |-> (way_wr == 2'b11 && way_en == 2'b11));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !req_en |-> (!hit && !rd_valid && !rd_dirty && way_en == 2'b00 && way_wr == 2'b00));
endmodule

bind way_pair_ctrl way_pair_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_en     (req_en),
  .req_cmp    (req_cmp),
  .req_wr     (req_wr),
  .req_count  (req_count),
  .way_hit    (way_hit),
  .way_valid  (way_valid),
  .hit        (hit),
  .rd_valid   (rd_valid),
  .rd_dirty   (rd_dirty),
  .victim_way (victim_way),
  .way_en     (way_en),
  .way_wr     (way_wr)
);

// File: tb/way_pair_ctrl_tb.sv
module way_pair_ctrl_tb;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 16;
  localparam int TAG_W  = 5;

  logic clk = 1'b0;
  logic rst;
  logic req_en, req_cmp, req_wr, req_count;
  logic [1:0] way_hit, way_valid, way_dirty;
  logic [1:0][TAG_W-1:0]  way_tag;
  logic [1:0][DATA_W-1:0] way_data;
  logic hit, rd_valid, rd_dirty, victim_way;
  logic [DATA_W-1:0] rd_data;
  logic [TAG_W-1:0]  rd_tag;
  logic [1:0] way_en, way_wr;

  int checks = 0;
  int errors = 0;

  logic m_vw;
  logic m_vict;

  logic             st_valid [2][2];
  logic [TAG_W-1:0] st_tag   [2][2];

  always #(CLK_P/2) clk = ~clk;

  way_pair_ctrl #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst(rst), .req_en(req_en), .req_cmp(req_cmp), .req_wr(req_wr),
    .req_count(req_count), .way_hit(way_hit), .way_valid(way_valid),
    .way_dirty(way_dirty), .way_tag(way_tag), .way_data(way_data),
    .hit(hit), .rd_data(rd_data), .rd_tag(rd_tag), .rd_valid(rd_valid),
    .rd_dirty(rd_dirty), .victim_way(victim_way), .way_en(way_en), .way_wr(way_wr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Victim chosen per R3/R4 given valid bits and post-toggle bit
  function automatic logic exp_pick(input logic [1:0] v, input logic post);
    if (v == 2'b11) return post;
    if (v == 2'b01) return 1'b1;
    return 1'b0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_en = 0; req_cmp = 0; req_wr = 0; req_count = 0;
    way_hit = 0; way_valid = 0; way_dirty = 0; way_tag = '0; way_data = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_vw = 1'b0;
    m_vict = 1'b0;
  endtask

  // One random cycle checked against the requirement model
  task automatic rand_cycle();
    logic [1:0] q;
    logic any, post, sel;
    logic [1:0] e_en, e_wr;
    @(negedge clk);
    req_en    = ($urandom % 8) != 0;
    req_cmp   = $urandom % 2;
    req_wr    = $urandom % 2;
    req_count = ($urandom % 4) != 0;
    way_hit   = $urandom % 4;
    way_valid = $urandom % 4;
    way_dirty = $urandom % 4;
    way_tag[0] = $urandom; way_tag[1] = $urandom;
    way_data[0] = $urandom; way_data[1] = $urandom;
    #2;
    q    = way_hit & way_valid;
    any  = req_en && req_cmp && (q != 2'b00);
    post = m_vw ^ (req_en & req_count);
    if (req_cmp) sel = any ? (q[0] ? 1'b0 : 1'b1) : exp_pick(way_valid, post);
    else         sel = m_vict;
    chk("R1 hit", hit, any);
    chk("R6 victim_way", victim_way, m_vict);
    if (!req_en) begin
      chk("R10 idle fields", {rd_data, rd_tag, rd_valid, rd_dirty}, '0);
      chk("R10 idle strobes", {way_en, way_wr}, 4'b0);
    end else begin
      chk(any ? "R2 data" : (req_cmp ? "R7 miss data" : "R7 raw data"), rd_data, way_data[sel]);
      chk("R2/R7 tag", rd_tag, way_tag[sel]);
      chk("R2/R7 valid dirty", {rd_valid, rd_dirty}, {way_valid[sel], way_dirty[sel]});
      e_en = req_cmp ? 2'b11 : (m_vict ? 2'b10 : 2'b01);
      e_wr = req_wr ? e_en : 2'b00;
      chk(req_cmp ? "R9 way_en" : "R8 way_en", way_en, e_en);
      chk(req_cmp ? "R9 way_wr" : "R8 way_wr", way_wr, e_wr);
    end
    if (req_en && req_cmp && req_count && !any) m_vict = exp_pick(way_valid, post);
    m_vw = post; // R5
  endtask

  // Directed load over two sets with behavioural storage
  task automatic do_load(input logic [15:0] addr, input int exp_way);
    logic s;
    logic [TAG_W-1:0] t;
    s = addr[4];
    t = TAG_W'(addr[14:12]);
    @(negedge clk);
    req_en = 1; req_cmp = 1; req_wr = 0; req_count = 1;
    for (int w = 0; w < 2; w++) begin
      way_hit[w]   = (st_tag[w][s] == t);
      way_valid[w] = st_valid[w][s];
      way_tag[w]   = st_tag[w][s];
      way_data[w]  = 16'(w + 1);
    end
    way_dirty = 2'b00;
    #2;
    chk("R1 sequence hit", hit, exp_way < 0);
    if (exp_way < 0) chk("R2 sequence data", rd_data, 16'd1);
    if (exp_way >= 0) begin
      @(negedge clk);
      chk("R6 sequence capture", victim_way, exp_way[0]);
      req_cmp = 0; req_wr = 1; req_count = 0;
      #2;
      chk("R8 sequence fill strobe", way_wr, exp_way[0] ? 2'b10 : 2'b01);
      for (int w = 0; w < 2; w++)
        if (way_wr[w]) begin
          st_valid[w][s] = 1'b1;
          st_tag[w][s]   = t;
        end
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 2; s++) begin
        st_valid[w][s] = 1'b0;
        st_tag[w][s]   = '0;
      end
    do_reset();
    #2;
    chk("R10 reset outputs", {hit, rd_data, rd_tag, rd_valid, rd_dirty, way_en, way_wr}, '0);
    chk("R6 reset victim", victim_way, 1'b0);

    // R3 R4 R5 install sequence: free-way preference then toggle eviction
    do_load(16'h1000, 0);
    do_load(16'h1010, 0);
    do_load(16'h1000, -1);
    do_load(16'h2010, 1);
    do_load(16'h2000, 1);
    do_load(16'h3000, 0);
    do_load(16'h3010, 1);

    // R7 raw read after last fill comes from held way 1
    @(negedge clk);
    req_en = 1; req_cmp = 0; req_wr = 0; req_count = 0;
    way_tag[0] = 5'h0A; way_tag[1] = 5'h15;
    #2;
    chk("R7 raw read tag", rd_tag, 5'h15);

    // R5 uncounted accesses leave the bit alone: both-valid miss picks post-toggle
    do_reset();
    req_en = 1; req_cmp = 0; req_wr = 0; req_count = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    req_cmp = 1; req_count = 1; way_valid = 2'b11; way_hit = 2'b00;
    @(negedge clk);
    chk("R5 uncounted skip", victim_way, 1'b1);
    req_count = 0;
    @(negedge clk);
    chk("R6 uncounted miss holds", victim_way, 1'b1);

    do_reset();
    for (int i = 0; i < 600; i++) rand_cycle();

    @(negedge clk);
    req_en = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule